// File: doc/BRIEF.md
# Split Sum of Absolute Differences Unit

This block is a datapath for motion-estimation kernels. Each cycle it can take two 128-bit vectors of sixteen unsigned byte elements. It forms the absolute difference of every matching byte pair and adds those differences in two independent groups. The first group is byte lanes 0 to 7 and the second group is byte lanes 8 to 15. It does not produce one scalar total.

Each group total is at most 2040, so it fits in 11 bits. The total is zero-extended into the lowest 16 bits of its own 64-bit half of the result, and every other bit of that half is zero. A block-matching engine streams candidate and reference rows into the unit, one vector per clock. It collects the two partial totals two clocks later, qualified by a valid strobe.

Top module: `hsad_top`

## Requirements
- R1: While reset is asserted and after it, until the first valid result arrives, validOut is 0 and result is all zero.
- R2: validOut is validIn delayed by exactly two clock edges.
- R3: The difference for each byte pair is |a-b| of the two unsigned bytes. It never wraps, whichever operand is larger.
- R4: result[15:0] holds the sum of the differences of byte lanes 0..7, where lane k is bits [8k+7:8k].
- R5: result[79:64] holds the sum of the differences of byte lanes 8..15.
- R6: result[63:16] and result[127:80] are always zero.
- R7: Two identical input vectors give an all-zero result.
- R8: All bytes 0x00 against all bytes 0xFF gives 0x07F8 in result[15:0] and 0x07F8 in result[79:64].
- R9: A new vector is accepted on every clock. Back-to-back valid inputs give back-to-back results, in input order.
- R10: Operands presented while validIn is 0 are ignored. The result keeps the last valid value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operands valid this cycle |
| opA | input | 128 | First vector, sixteen unsigned bytes |
| opB | input | 128 | Second vector, sixteen unsigned bytes |
| validOut | output | 1 | Result valid |
| result | output | 128 | Two half-sums, each at the bottom of its 64-bit half |

## Verification
A stuck or skipped stage in the valid pipeline shows up on validOut in the same cycle it goes wrong. It is visible two clocks after the input that exposes it. A wrong pair register or group register corrupts the 16-bit field of exactly one half at the next result. Lane-swapped or wrapped differences only appear when byte lanes differ in sign of a-b. For that reason the stimulus mixes directions, feeds one half at a time, and includes idle gaps to expose loads while validIn is 0.

// File: rtl/hsad_pkg.sv
package hsad_pkg;
  // Load strobes sent from control to datapath each cycle
  typedef struct packed {
    logic loadPairs;  // capture pairwise difference sums
    logic loadSums;   // capture group totals
  } hsadStrobe_t;
endpackage

// File: rtl/hsad_ctrl.sv
module hsad_ctrl
  import hsad_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        validIn,
  output hsadStrobe_t strobe,
  output logic        validOut
);
  logic vld1, vld2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1 <= 1'b0;
      vld2 <= 1'b0;
    end else begin
      vld1 <= validIn;
      vld2 <= vld1;
    end
  end

  always_comb begin
    strobe.loadPairs = validIn;
    strobe.loadSums  = vld1;
  end
  assign validOut = vld2;

  // cycles since reset, saturating, so $past(,2) only looks at post-reset values
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warmCnt <= 2'd0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  // R2
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warmCnt >= 2'd2) |-> (validOut == $past(validIn, 2)));

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warmCnt == 2'd0) |-> !validOut);
endmodule

// File: rtl/hsad_datapath.sv
module hsad_datapath
  import hsad_pkg::*;
#(
  parameter int ELEM_W = 8,
  parameter int LANES  = 16,
  parameter int FIELD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  hsadStrobe_t             strobe,
  input  logic [LANES*ELEM_W-1:0] opA,
  input  logic [LANES*ELEM_W-1:0] opB,
  output logic [LANES*ELEM_W-1:0] result
);
  localparam int VEC_W   = LANES * ELEM_W;
  localparam int HALF_W  = VEC_W / 2;
  localparam int GROUPS  = 2;
  localparam int GROUP   = LANES / GROUPS;
  localparam int NPAIR   = LANES / 2;
  localparam int PAIRS_G = GROUP / 2;
  localparam int PAIR_W  = ELEM_W + 1;
  localparam int SUM_W   = ELEM_W + $clog2(GROUP);
  localparam int MAX_SUM = GROUP * ((1 << ELEM_W) - 1);
  localparam int MAX_PAIR = 2 * ((1 << ELEM_W) - 1);

  logic [ELEM_W-1:0] absDiff [LANES];
  logic [PAIR_W-1:0] pairNext [NPAIR];
  logic [PAIR_W-1:0] pairReg [NPAIR];
  logic [SUM_W-1:0]  sumNext [GROUPS];
  logic [SUM_W-1:0]  sumReg [GROUPS];

  // per-lane absolute difference chosen by unsigned compare, no wrap
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ELEM_W-1:0] a, b;
    assign a = opA[l*ELEM_W +: ELEM_W];
    assign b = opB[l*ELEM_W +: ELEM_W];
    assign absDiff[l] = (a >= b) ? (a - b) : (b - a);
  end

  // first tree level: adjacent lanes
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pairNext[p] = {1'b0, absDiff[2*p]} + {1'b0, absDiff[2*p+1]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pairReg[p] <= '0;
      else if (strobe.loadPairs) pairReg[p] <= pairNext[p];
    end

    // R3
    pair_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pairReg[p]) <= MAX_PAIR);
  end

  // second tree level: per group total
  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    always_comb begin
      sumNext[g] = '0;
      for (int k = 0; k < PAIRS_G; k++)
        sumNext[g] = sumNext[g] + SUM_W'(pairReg[g*PAIRS_G + k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sumReg[g] <= '0;
      else if (strobe.loadSums) sumReg[g] <= sumNext[g];
    end

    assign result[g*HALF_W +: HALF_W] = HALF_W'(sumReg[g]);

    // R4
    sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(sumReg[g]) <= MAX_SUM);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe.loadSums |=> $stable(result[g*HALF_W +: FIELD_W]));
  end
endmodule

// File: rtl/hsad_top.sv
module hsad_top
  import hsad_pkg::*;
#(
  parameter int ELEM_W  = 8,
  parameter int LANES   = 16,
  parameter int FIELD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    validIn,
  input  logic [LANES*ELEM_W-1:0] opA,
  input  logic [LANES*ELEM_W-1:0] opB,
  output logic                    validOut,
  output logic [LANES*ELEM_W-1:0] result
);
  localparam int HALF_W = LANES * ELEM_W / 2;

  hsadStrobe_t strobe;

  hsad_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  hsad_datapath #(
    .ELEM_W (ELEM_W),
    .LANES  (LANES),
    .FIELD_W(FIELD_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result[FIELD_W +: HALF_W-FIELD_W] == '0) &&
    (result[HALF_W+FIELD_W +: HALF_W-FIELD_W] == '0));
endmodule

// File: tb/test_hsad_top.sv
module test_hsad_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         validIn = 1'b0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic         validOut;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  string curTag = "";

  logic         qV[$];
  logic [127:0] qR[$];
  logic [127:0] lastRes = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsad_top i_hsad_top (
    .clk(clk), .rst_n(rst_n), .validIn(validIn),
    .opA(opA), .opB(opB), .validOut(validOut), .result(result)
  );

  function automatic logic [127:0] sadRef(input logic [127:0] a, input logic [127:0] b);
    int lo = 0;
    int hi = 0;
    for (int i = 0; i < 16; i++) begin
      int x = int'(a[i*8 +: 8]);
      int y = int'(b[i*8 +: 8]);
      int d = (x > y) ? x - y : y - x;
      if (i < 8) lo += d; else hi += d;
    end
    sadRef = '0;
    sadRef[15:0]  = 16'(lo);
    sadRef[79:64] = 16'(hi);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareOut();
    logic ev;
    logic [127:0] er;
    string tagV, tagLo, tagHi;
    ev = qV.pop_front();
    er = qR.pop_front();
    if (ev) lastRes = er;
    tagV  = (curTag == "R9") ? "R9" : "R2";
    tagLo = (curTag == "") ? "R4" : curTag;
    tagHi = (curTag == "") ? "R5" : curTag;
    check(validOut == ev, tagV, 64'(validOut), 64'(ev));
    check(result[15:0] == lastRes[15:0], tagLo, 64'(result[15:0]), 64'(lastRes[15:0]));
    check(result[79:64] == lastRes[79:64], tagHi, 64'(result[79:64]), 64'(lastRes[79:64]));
    check(result[63:16] == '0 && result[127:80] == '0, "R6",
          {16'h0, result[63:16]} | {16'h0, result[127:80]}, 64'h0);
  endtask

  task automatic step(input logic v, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    compareOut();
    validIn = v;
    opA = a;
    opB = b;
    qV.push_back(v);
    qR.push_back(sadRef(a, b));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R1: outputs idle during reset
    opA = {16{8'h5A}};
    opB = {16{8'h11}};
    repeat (3) @(negedge clk);
    check(validOut == 1'b0, "R1", 64'(validOut), 64'h0);
    check(result == '0, "R1", result[63:0] | result[127:64], 64'h0);
    rst_n = 1'b1;
    validIn = 1'b0;
    qV.push_back(1'b0); qR.push_back('0);
    qV.push_back(1'b0); qR.push_back('0);

    curTag = "R1";
    step(1'b0, {16{8'hFF}}, '0);
    step(1'b0, {16{8'hFF}}, '0);

    // R8: all zero against all ones, both operand orders
    curTag = "R8";
    step(1'b1, '0, {16{8'hFF}});
    step(1'b1, {16{8'hFF}}, '0);

    // R7: identical operands
    curTag = "R7";
    for (int i = 0; i < 6; i++) begin
      logic [127:0] v = rnd128();
      step(1'b1, v, v);
    end

    // R3: mixed directions per lane, small and large gaps
    curTag = "R3";
    step(1'b1, 128'h00FF_01FE_7F80_8000_FF00_FE01_807F_0080,
               128'hFF00_FE01_807F_0080_00FF_01FE_7F80_8000);
    step(1'b1, 128'h0102_0304_0506_0708_F0E0_D0C0_B0A0_9080,
               128'h0201_0403_0605_0807_E0F0_C0D0_A0B0_8090);

    // R4 / R5: only one half differs
    curTag = "";
    step(1'b1, {64'h0, 64'h1122_3344_5566_7788}, '0);
    step(1'b1, {64'hA0B0_C0D0_E0F0_0010, 64'h0}, '0);

    // R9: back-to-back random stream
    curTag = "R9";
    for (int i = 0; i < 40; i++) step(1'b1, rnd128(), rnd128());

    // R10: operands change while validIn low
    curTag = "R10";
    for (int i = 0; i < 30; i++) step(1'(i % 3 == 0), rnd128(), rnd128());
    for (int i = 0; i < 4; i++) step(1'b0, rnd128(), rnd128());

    // general random with random valid pattern
    curTag = "";
    for (int i = 0; i < 100; i++) step(1'($urandom_range(0, 1)), rnd128(), rnd128());

    curTag = "R10";
    step(1'b0, rnd128(), rnd128());
    step(1'b0, rnd128(), rnd128());
    step(1'b0, rnd128(), rnd128());
    finishRun();
  end
endmodule